// File: doc/BRIEF.md
# MII Transmit Nibble Framer

This block sits on the MAC side of a 4-bit media-independent interface and turns a byte stream into the nibble stream the PHY expects. It runs entirely in the transmit clock domain that the PHY supplies: 2.5 MHz for 10 Mb/s operation and 25 MHz for 100 Mb/s. The byte source offers frame bytes on a valid/ready handshake, with a last flag on the final byte. The block has no other setting to change between the two rates.

For each frame the block produces the whole nibble sequence. It starts with a preamble of repeated 0x5 nibbles and a single 0xD start nibble. Each payload byte follows, low nibble first and then high nibble. The transmit enable is raised with the first preamble nibble and dropped right after the final high nibble. Between frames the data lines rest at 0000, and a minimum idle time is enforced before the next preamble may begin. The block does not add a CRC or padding. The transmit-error output is always held low.

Top module: `mii_tx_framer`

## Requirements
- R1: While reset is applied, and in the first cycle after it, mii_txen, mii_txd, mii_txer and in_ready are all 0.
- R2: When in_valid is seen high in idle, mii_txen rises on the next clock edge together with the first preamble nibble. The frame begins with 15 nibbles of 0x5 and then one nibble of 0xD.
- R3: After the 0xD nibble, every byte is sent as two nibbles, bits [3:0] first and bits [7:4] second. in_ready is 1 only during the cycle that carries a byte's low nibble, and the byte is consumed at the end of that cycle.
- R4: mii_txen stays 1 without a gap for the whole frame. A frame of N bytes keeps it high for exactly 16 + 2N consecutive cycles.
- R5: mii_txen falls on the clock edge right after the high nibble of the byte marked last. mii_txd is 0000 in every cycle in which mii_txen is 0.
- R6: After a frame, mii_txen stays low for at least 24 cycles. If the next frame is already waiting, its first preamble nibble appears exactly 24 cycles after mii_txen fell.
- R7: If in_valid is low when the next byte is due after a high nibble, the frame ends there in the same way as after a last byte. No further frame starts until in_valid returns.
- R8: mii_txer is 0 in every cycle.
- R9: While no frame is in progress and in_valid is low, changes on in_data have no effect: mii_txen stays 0 and mii_txd stays 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock sourced by the PHY |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Frame byte offered by the source |
| in_valid | input | 1 | in_data holds a valid byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | High in the cycle where the offered byte is consumed |
| mii_txen | output | 1 | Transmit enable toward the PHY |
| mii_txd | output | 4 | Transmit nibble toward the PHY |
| mii_txer | output | 1 | Transmit error, held low |

## Verification
Two situations are the hardest to reach from the ports. The first is the exact 24-cycle gap, which only shows when a second frame is already waiting as the first one closes. The bench covers it by offering both frames as one continuous byte list, with in_valid kept high across the boundary. The second is ending a frame on a starved source. To reach it, the bench drops in_valid right after the last byte without a last flag, and then confirms that the frame closes after that byte's high nibble and that nothing restarts.

// File: rtl/mii_tx_pkg.sv
`timescale 1ns/1ps
package mii_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_SFD  = 3'd2,
      ST_LO   = 3'd3,
      ST_HI   = 3'd4,
      ST_GAP  = 3'd5
   } tx_state_t;

endpackage

// File: rtl/mii_tx_ctrl.sv
`timescale 1ns/1ps
module mii_tx_ctrl
   import mii_tx_pkg::*;
#(
   parameter int PRE_NIB = 15,
   parameter int IFG_NIB = 24
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      in_valid,
   input  logic      in_last,
   output logic      in_ready,
   output tx_state_t state_q,
   output tx_state_t nxt_state
);

   localparam int CNT_MAX = (PRE_NIB > IFG_NIB) ? PRE_NIB : IFG_NIB;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] PRE_END = CNT_W'(PRE_NIB - 1);
   localparam logic [CNT_W-1:0] GAP_END = CNT_W'(IFG_NIB - 1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last_q, last_d;

   always_comb begin
      nxt_state = state_q;
      cnt_d     = cnt_q;
      last_d    = last_q;
      case (state_q)
         ST_IDLE: begin
            if (in_valid) begin
               nxt_state = ST_PRE;
               cnt_d     = '0;
            end
         end
         ST_PRE: begin
            if (cnt_q == PRE_END) nxt_state = ST_SFD;
            else                  cnt_d     = cnt_q + 1'b1;
         end
         ST_SFD: begin
            if (in_valid) nxt_state = ST_LO;
            else begin
               nxt_state = ST_GAP;
               cnt_d     = '0;
            end
         end
         ST_LO: begin
            nxt_state = ST_HI;
            last_d    = in_last;
         end
         ST_HI: begin
            if (last_q || !in_valid) begin
               nxt_state = ST_GAP;
               cnt_d     = '0;
            end else begin
               nxt_state = ST_LO;
            end
         end
         ST_GAP: begin
            if (cnt_q == GAP_END) begin
               nxt_state = in_valid ? ST_PRE : ST_IDLE;
               cnt_d     = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            nxt_state = ST_IDLE;
            cnt_d     = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         last_q  <= 1'b0;
      end else begin
         state_q <= nxt_state;
         cnt_q   <= cnt_d;
         last_q  <= last_d;
      end
   end

   assign in_ready = (state_q == ST_LO);

   // R2: the start nibble always follows a complete preamble run
   assert_sfd_after_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SFD) |-> ($past(state_q) == ST_PRE && $past(cnt_q) == PRE_END));

endmodule

// File: rtl/mii_tx_nib_out.sv
`timescale 1ns/1ps
module mii_tx_nib_out
   import mii_tx_pkg::*;
#(
   parameter int                NIB_W    = 4,
   parameter logic [NIB_W-1:0]  PRE_CODE = 4'h5,
   parameter logic [NIB_W-1:0]  SFD_CODE = 4'hD,
   parameter bit                TXER_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  tx_state_t            nxt_state,
   input  logic [2*NIB_W-1:0]   byte_in,
   output logic                 txen,
   output logic [NIB_W-1:0]     txd,
   output logic                 txer
);

   localparam int NIBS = 2;

   logic [NIB_W-1:0] nib [NIBS];
   logic             en_d;
   logic [NIB_W-1:0] nib_d;

   for (genvar g = 0; g < NIBS; g++) begin : g_split
      assign nib[g] = byte_in[g*NIB_W +: NIB_W];
   end

   always_comb begin
      en_d  = 1'b1;
      nib_d = '0;
      case (nxt_state)
         ST_PRE:  nib_d = PRE_CODE;
         ST_SFD:  nib_d = SFD_CODE;
         ST_LO:   nib_d = nib[0];
         ST_HI:   nib_d = nib[1];
         default: en_d  = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txen <= 1'b0;
         txd  <= '0;
      end else begin
         txen <= en_d;
         txd  <= nib_d;
      end
   end

   if (TXER_REG) begin : g_txer_reg
      logic txer_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) txer_q <= 1'b0;
         else        txer_q <= 1'b0;
      end
      assign txer = txer_q;
   end else begin : g_txer_tie
      assign txer = 1'b0;
   end

   // R5: idle lines rest at zero
   assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !txen |-> (txd == '0));

   // R2: enable rises together with a preamble nibble
   assert_rise_on_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txen) |-> (txd == PRE_CODE));

   // R8: error output never raised
   assert_txer_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !txer);

endmodule

// File: rtl/mii_tx_framer.sv
`timescale 1ns/1ps
module mii_tx_framer
   import mii_tx_pkg::*;
#(
   parameter int               NIB_W    = 4,
   parameter int               PRE_NIB  = 15,
   parameter int               IFG_NIB  = 24,
   parameter logic [NIB_W-1:0] PRE_CODE = 4'h5,
   parameter logic [NIB_W-1:0] SFD_CODE = 4'hD,
   parameter bit               TXER_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*NIB_W-1:0] in_data,
   input  logic               in_valid,
   input  logic               in_last,
   output logic               in_ready,
   output logic               mii_txen,
   output logic [NIB_W-1:0]   mii_txd,
   output logic               mii_txer
);

   localparam int BYTE_W = 2 * NIB_W;
   localparam int GAPW   = $clog2(IFG_NIB + 1);
   localparam logic [GAPW-1:0] GAP_SAT = GAPW'(IFG_NIB);

   if (NIB_W < 1) begin : g_bad_nib
      $error("NIB_W must be at least 1");
   end
   if (PRE_NIB < 1) begin : g_bad_pre
      $error("PRE_NIB must be at least 1");
   end
   if (IFG_NIB < 1) begin : g_bad_ifg
      $error("IFG_NIB must be at least 1");
   end
   if (PRE_CODE == SFD_CODE) begin : g_bad_codes
      $error("preamble and start codes must differ");
   end

   tx_state_t state_q, nxt_state;

   mii_tx_ctrl #(
      .PRE_NIB (PRE_NIB),
      .IFG_NIB (IFG_NIB)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_ready  (in_ready),
      .state_q   (state_q),
      .nxt_state (nxt_state)
   );

   mii_tx_nib_out #(
      .NIB_W    (NIB_W),
      .PRE_CODE (PRE_CODE),
      .SFD_CODE (SFD_CODE),
      .TXER_REG (TXER_REG)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_state (nxt_state),
      .byte_in   (in_data),
      .txen      (mii_txen),
      .txd       (mii_txd),
      .txer      (mii_txer)
   );

   // Low-run counter for the gap check
   logic [GAPW-1:0] low_run;
   logic            seen_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run    <= '0;
         seen_frame <= 1'b0;
      end else if (mii_txen) begin
         low_run    <= '0;
         seen_frame <= 1'b1;
      end else if (low_run != GAP_SAT) begin
         low_run <= low_run + 1'b1;
      end
   end

   // R6: minimum idle time between frames
   assert_min_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mii_txen) && seen_frame) |-> (low_run >= GAP_SAT));

   // R3: a consumed byte shows its high nibble next
   assert_hi_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (mii_txen && mii_txd == $past(in_data[BYTE_W-1:NIB_W])));

   // R3: bytes are only taken inside an active frame
   assert_ready_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> mii_txen);

   // R4: the frame closes only after a high nibble
   assert_end_after_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mii_txen) |-> ($past(state_q) == ST_HI || $past(state_q) == ST_SFD));

endmodule

// File: tb/mii_tx_framer_test.sv
`timescale 1ns/1ps
module mii_tx_framer_test;

   localparam int IFG_NIB = 24;
   localparam int LOGN    = 512;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready, txen, txer;
   logic [3:0] txd;

   int errors = 0;
   int checks = 0;

   logic [7:0] tx_byte [64];
   bit         tx_last [64];
   bit         en_log [LOGN];
   logic [3:0] d_log  [LOGN];
   bit         r_log  [LOGN];
   bit         er_log [LOGN];
   int         log_n;

   always #2.5 clk = ~clk;

   mii_tx_framer uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (in_data),
      .in_valid (in_valid),
      .in_last  (in_last),
      .in_ready (in_ready),
      .mii_txen (txen),
      .mii_txd  (txd),
      .mii_txer (txer)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input int n, input logic [7:0] seed);
      for (int k = 0; k < n; k++) begin
         tx_byte[k] = seed + 8'(k * 37) ^ 8'(k << 4);
         tx_last[k] = 1'b0;
      end
   endtask

   // Drives a byte list (handshake observed at negedges) and logs outputs
   task automatic drive(input int total, input int cycles);
      int  i = 0;
      bit  took = 1'b0;
      log_n = 0;
      if (total > 0) begin
         in_valid = 1'b1;
         in_data  = tx_byte[0];
         in_last  = tx_last[0];
      end
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         if (took) begin
            i++;
            if (i < total) begin
               in_data = tx_byte[i];
               in_last = tx_last[i];
            end else begin
               in_valid = 1'b0;
               in_last  = 1'b0;
               in_data  = 8'hA7 ^ 8'(c);
            end
         end
         en_log[c] = txen;
         d_log[c]  = txd;
         r_log[c]  = in_ready;
         er_log[c] = txer;
         log_n     = c + 1;
         took      = in_valid && in_ready;
      end
   endtask

   task automatic check_frame(input int from, input int nb, input int b0,
                              output int s, output int e);
      int bad;
      int run;
      s = -1;
      for (int k = from; k < log_n; k++) if (en_log[k] && s < 0) s = k;
      check(s >= 0, "R2", "frame start found", s, from);
      if (s < 0) begin
         e = from;
         return;
      end
      bad = 0;
      for (int k = 0; k < 15; k++) if (!en_log[s+k] || d_log[s+k] != 4'h5) bad++;
      check(bad == 0, "R2", "preamble nibbles wrong", bad, 0);
      check(en_log[s+15] && d_log[s+15] == 4'hD, "R2", "start nibble", int'(d_log[s+15]), 13);
      bad = 0;
      for (int j = 0; j < nb; j++) begin
         if (!en_log[s+16+2*j]   || d_log[s+16+2*j]   != tx_byte[b0+j][3:0]) bad++;
         if (!en_log[s+17+2*j]   || d_log[s+17+2*j]   != tx_byte[b0+j][7:4]) bad++;
      end
      check(bad == 0, "R3", "payload nibble order", bad, 0);
      bad = 0;
      for (int k = s; k < s + 16 + 2*nb; k++) begin
         if (r_log[k] != ((k >= s + 16) && (((k - s - 16) % 2) == 0))) bad++;
      end
      check(bad == 0, "R3", "ready pattern", bad, 0);
      run = 0;
      for (int k = s; k < log_n && en_log[k]; k++) run++;
      check(run == 16 + 2*nb, "R4", "txen high run length", run, 16 + 2*nb);
      e = s + 16 + 2*nb;
      check(!en_log[e], "R5", "txen low after last nibble", int'(en_log[e]), 0);
   endtask

   task automatic check_log_idle();
      int bad = 0;
      int bad_er = 0;
      for (int k = 0; k < log_n; k++) begin
         if (!en_log[k] && d_log[k] != 4'h0) bad++;
         if (er_log[k]) bad_er++;
      end
      check(bad == 0, "R5", "nonzero txd while txen low", bad, 0);
      check(bad_er == 0, "R8", "txer raised", bad_er, 0);
   endtask

   task automatic test_reset();
      in_valid = 1'b1;
      in_data  = 8'hFF;
      repeat (3) @(negedge clk);
      check(!txen && txd == 4'h0 && !in_ready && !txer, "R1", "outputs during reset",
            {txen, txd, in_ready, txer}, 0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!txen && txd == 4'h0 && !in_ready && !txer, "R1", "outputs after reset",
            {txen, txd, in_ready, txer}, 0);
   endtask

   task automatic test_idle_noise();
      int bad = 0;
      in_valid = 1'b0;
      for (int c = 0; c < 30; c++) begin
         in_data = 8'(c * 29 + 3);
         in_last = c[0];
         @(negedge clk);
         if (txen || txd != 4'h0 || in_ready) bad++;
      end
      in_last = 1'b0;
      check(bad == 0, "R9", "idle outputs moved by in_data", bad, 0);
   endtask

   task automatic test_single();
      int s, e;
      fill(1, 8'h9C);
      tx_last[0] = 1'b1;
      drive(1, 40);
      check_frame(0, 1, 0, s, e);
      check(s == 0, "R2", "start latency", s, 0);
      check_log_idle();
   endtask

   task automatic test_long();
      int s, e;
      fill(40, 8'h3B);
      tx_last[39] = 1'b1;
      drive(40, 120);
      check_frame(0, 40, 0, s, e);
      check_log_idle();
   endtask

   task automatic test_back_to_back();
      int s1, e1, s2, e2;
      fill(6, 8'h61);
      tx_last[3] = 1'b1;
      tx_last[5] = 1'b1;
      drive(6, 110);
      check_frame(0, 4, 0, s1, e1);
      check_frame(e1, 2, 4, s2, e2);
      check(s2 - e1 == IFG_NIB, "R6", "gap with frame waiting", s2 - e1, IFG_NIB);
      check_log_idle();
   endtask

   task automatic test_late_second();
      int s1, e1, s2, e2;
      fill(3, 8'h17);
      tx_last[2] = 1'b1;
      drive(3, 60);
      check_frame(0, 3, 0, s1, e1);
      tx_byte[0] = 8'hE2;
      tx_last[0] = 1'b1;
      drive(1, 30);
      check_frame(0, 1, 0, s2, e2);
      check(s2 == 0, "R6", "start after long idle", s2, 0);
   endtask

   task automatic test_underrun();
      int s, e;
      int bad = 0;
      fill(3, 8'hC4);
      drive(3, 80);
      check_frame(0, 3, 0, s, e);
      for (int k = e; k < log_n; k++) if (en_log[k]) bad++;
      check(bad == 0, "R7", "restart after starved frame", bad, 0);
      check_log_idle();
   endtask

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      test_reset();
      test_idle_noise();
      test_single();
      repeat (30) @(negedge clk);
      test_long();
      repeat (30) @(negedge clk);
      test_back_to_back();
      repeat (30) @(negedge clk);
      test_late_second();
      repeat (30) @(negedge clk);
      test_underrun();
      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule